// File: doc/BRIEF.md
# UART Receive Buffer with Error Status

This block sits between a UART's serial deserializer and its data register. Each received character arrives as a 12-bit entry: the low eight bits carry the character and the upper four bits carry per-character condition flags. A break condition is delivered as an entry with only bit 10 set. Entries are held in a circular store of sixteen slots. A read of the data register takes the oldest entry out and returns it.

A control-register write selects one of two depths at run time. With the buffer enabled, up to sixteen characters wait. With it disabled, the block acts as a single holding register. Any write that changes the enable bit discards the contents. The block also drives an empty flag, a full flag, a can-accept signal and a level-1 receive interrupt. When an entry is read, its flag nibble is copied into a separate status register, and software clears that register by writing to it.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, rx_empty is 1, rx_full is 0, rx_irq is 0, rx_stat is 0, push_ready is 1, and the block is in single-entry mode.
- R2: An entry is 12 bits: bits 7:0 hold the character, bits 11:8 hold the condition flags, and bit 10 alone marks a break (value 0x400). Entries are returned in arrival order with all 12 bits unchanged.
- R3: push_ready is high while the stored count is below the active depth. The active depth is 16 when buffering is enabled and 1 when it is disabled. A push while push_ready is low is dropped and writes no slot.
- R4: rx_full goes to 1 on an accepted push that brings the count to the active depth. That is every accepted push in single-entry mode. Any data read (rd_pop) clears it.
- R5: rx_empty goes to 0 on every accepted push. It goes to 1 when a data read leaves the count at zero.
- R6: A data read while the buffer is empty returns the stale slot at the read pointer and changes neither the pointer nor the count.
- R7: The cycle after a data read, rx_stat holds bits 11:8 of the entry returned. A stat_clr pulse without a data read sets rx_stat to zero.
- R8: rx_irq goes to 1 when an accepted push brings the count to 1. It goes to 0 when a data read leaves the count at 0.
- R9: A lcr_wr whose lcr_fifo_en differs from the current mode discards all entries. It returns both pointers to slot 0 and sets rx_empty to 1, rx_full to 0 and rx_irq to 0. A lcr_wr with the same value has no effect on the contents.
- R10: An accepted push together with a data read of a non-empty buffer leaves the count unchanged and advances both pointers.
- R11: Both pointers wrap from slot 15 to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Deserializer offers an entry |
| push_entry | input | 12 | Entry: flags in 11:8, character in 7:0 |
| push_ready | output | 1 | Buffer can accept an entry this cycle |
| rd_pop | input | 1 | Data register read strobe |
| rd_entry | output | 12 | Entry at the read pointer |
| lcr_wr | input | 1 | Line control register write strobe |
| lcr_fifo_en | input | 1 | Buffer-enable bit value written with lcr_wr |
| stat_clr | input | 1 | Write to receive status register, clears it |
| rx_stat | output | 4 | Flags of the last entry read |
| rx_empty | output | 1 | Empty flag |
| rx_full | output | 1 | Full flag |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The hardest state to reach from the ports is a stale read whose value can be predicted. This needs a read pointer that has travelled all the way round the ring, or one that a flush has reset onto a slot still holding old data. The stimulus first pushes sixteen entries starting from slot 5, so the write pointer passes the wrap point. It then drains them and issues one more read on the empty buffer, which must return the first entry of that batch. It next toggles the mode bit and reads again; the read lands on slot 0, which the wrapped batch overwrote earlier. A dropped push in single-entry mode is shown by an empty read that still returns zero.

// File: rtl/uart_rxf_pkg.sv
// Shared widths and entry type for the UART receive buffer.
// Assumes an 8-bit character with a 4-bit flag nibble above it.
package uart_rxf_pkg;
    localparam int CHAR_W  = 8;
    localparam int FLAG_W  = 4;
    localparam int ENTRY_W = CHAR_W + FLAG_W;
    localparam int BRK_BIT = 10;
    typedef logic [ENTRY_W-1:0] rx_entry_t;
endpackage

// File: rtl/uart_rxf_mode.sv
// Holds the buffer-enable mode bit and flags a flush when a control write toggles it.
// Assumes lcr_wr is a single-cycle strobe.
module uart_rxf_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic lcr_wr,
    input  logic lcr_fifo_en,
    output logic fifo_en,
    output logic flush
);
    // A write carrying a different enable value empties the buffer.
    assign flush = lcr_wr && (lcr_fifo_en != fifo_en);

    // Mode register: follows every control write, resets to single-entry.
    always_ff @(posedge clk) begin
        if (!rst_n)      fifo_en <= 1'b0;
        else if (lcr_wr) fifo_en <= lcr_fifo_en;
    end
endmodule

// File: rtl/uart_rxf_ctrl.sv
// Occupancy counter, empty/full flags and receive interrupt level.
// Assumes a flush wins over any push or read in the same cycle.
module uart_rxf_ctrl #(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_en,
    input  logic flush,
    input  logic push_valid,
    input  logic pop,
    output logic push_ready,
    output logic wr_en,
    output logic rd_adv,
    output logic empty,
    output logic full,
    output logic irq
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] TRIG_C  = CW'(TRIG);
    localparam logic [CW-1:0] TRIGM_C = CW'(TRIG - 1);

    logic [CW-1:0] count, cnt_nxt, active;

    // Depth limit and accept/advance decisions for this cycle.
    always_comb begin
        active     = fifo_en ? DEPTH_C : CW'(1);
        push_ready = count < active;
        wr_en      = push_valid && push_ready && !flush;
        rd_adv     = pop && (count != '0) && !flush;
        cnt_nxt    = count + CW'(wr_en) - CW'(rd_adv);
    end

    // Count, flags and interrupt level update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count <= '0;
            empty <= 1'b1;
            full  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            count <= cnt_nxt;
            if (wr_en && cnt_nxt == active) full <= 1'b1;
            else if (pop)                   full <= 1'b0;
            if (wr_en)                      empty <= 1'b0;
            else if (pop && cnt_nxt == '0)  empty <= 1'b1;
            if (wr_en && cnt_nxt == TRIG_C)      irq <= 1'b1;
            else if (pop && cnt_nxt == TRIGM_C)  irq <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rxf_store.sv
// Circular entry store with read and write pointers.
// Assumes the controller never writes a full store; slots reset to zero.
module uart_rxf_store #(
    parameter int DEPTH = 16,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_adv,
    output logic [W-1:0] rd_data
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign rd_data = mem[rd_ptr];

    // Pointer movement, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en)  wr_ptr <= step(wr_ptr);
            if (rd_adv) rd_ptr <= step(rd_ptr);
        end
    end

    // Slot storage; contents survive a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end
endmodule

// File: rtl/uart_rxf_status.sv
// Receive status register: captures the flag nibble of each entry read.
// Assumes a data read and a clear in the same cycle resolve to the capture.
module uart_rxf_status #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          clr,
    input  logic [FW-1:0] flags_in,
    output logic [FW-1:0] stat
);
    // Capture on read, clear on software write.
    always_ff @(posedge clk) begin
        if (!rst_n)   stat <= '0;
        else if (pop) stat <= flags_in;
        else if (clr) stat <= '0;
    end
endmodule

// File: rtl/uart_rx_fifo.sv
// UART receive buffer top: 16-deep or single-entry store, flags, interrupt, status.
// Assumes rd_pop, lcr_wr and stat_clr are one-cycle register-access strobes.
module uart_rx_fifo
    import uart_rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_valid,
    input  logic [ENTRY_W-1:0] push_entry,
    output logic               push_ready,
    input  logic               rd_pop,
    output logic [ENTRY_W-1:0] rd_entry,
    input  logic               lcr_wr,
    input  logic               lcr_fifo_en,
    input  logic               stat_clr,
    output logic [FLAG_W-1:0]  rx_stat,
    output logic               rx_empty,
    output logic               rx_full,
    output logic               rx_irq
);
    logic fifo_en, flush, wr_en, rd_adv;

    uart_rxf_mode u_mode (
        .clk(clk), .rst_n(rst_n), .lcr_wr(lcr_wr), .lcr_fifo_en(lcr_fifo_en),
        .fifo_en(fifo_en), .flush(flush)
    );

    uart_rxf_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush),
        .push_valid(push_valid), .pop(rd_pop), .push_ready(push_ready),
        .wr_en(wr_en), .rd_adv(rd_adv), .empty(rx_empty), .full(rx_full),
        .irq(rx_irq)
    );

    uart_rxf_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
        .wr_data(push_entry), .rd_adv(rd_adv), .rd_data(rd_entry)
    );

    uart_rxf_status #(.FW(FLAG_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .pop(rd_pop), .clr(stat_clr),
        .flags_in(rd_entry[ENTRY_W-1:CHAR_W]), .stat(rx_stat)
    );
endmodule

// File: rtl/uart_rx_fifo_chk.sv
// Port-level properties of the receive buffer, bound to its top.
module uart_rx_fifo_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        push_valid,
    input logic        push_ready,
    input logic        rd_pop,
    input logic [11:0] rd_entry,
    input logic        lcr_wr,
    input logic        stat_clr,
    input logic [3:0]  rx_stat,
    input logic        rx_empty,
    input logic        rx_full,
    input logic        rx_irq
);
    // R4
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !push_ready);
    // R3
    empty_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> push_ready);
    // R8
    irq_on_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready && rx_empty && !lcr_wr) |=> (rx_irq && !rx_empty));
    // R7
    stat_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |=> (rx_stat == $past(rd_entry[11:8])));
    // R7
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !rd_pop) |=> (rx_stat == 4'h0));
    // R6
    stale_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && rx_empty && !push_valid && !lcr_wr) |=> (rx_empty && $stable(rd_entry)));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .rd_pop(rd_pop), .rd_entry(rd_entry), .lcr_wr(lcr_wr), .stat_clr(stat_clr),
    .rx_stat(rx_stat), .rx_empty(rx_empty), .rx_full(rx_full), .rx_irq(rx_irq)
);

// File: tb/uart_rx_fifo_bench.sv
module uart_rx_fifo_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [11:0] push_entry = '0;
    logic        push_ready;
    logic        rd_pop = 1'b0;
    logic [11:0] rd_entry;
    logic        lcr_wr = 1'b0;
    logic        lcr_fifo_en = 1'b0;
    logic        stat_clr = 1'b0;
    logic [3:0]  rx_stat;
    logic        rx_empty, rx_full, rx_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    uart_rx_fifo u_uart_rx_fifo (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_entry(push_entry),
        .push_ready(push_ready), .rd_pop(rd_pop), .rd_entry(rd_entry),
        .lcr_wr(lcr_wr), .lcr_fifo_en(lcr_fifo_en), .stat_clr(stat_clr),
        .rx_stat(rx_stat), .rx_empty(rx_empty), .rx_full(rx_full), .rx_irq(rx_irq)
    );

    // Vector: push, push data, pop, ready, empty, full, irq, stat, read data
    localparam logic [33:0] VECS [0:7] = '{
        {1'b1, 12'h041, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 12'h000},
        {1'b1, 12'h1A2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 12'h000},
        {1'b0, 12'h000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 12'h041},
        {1'b0, 12'h000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h1, 12'h1A2},
        {1'b1, 12'h400, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'h1, 12'h000},
        {1'b1, 12'h233, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'h4, 12'h400},
        {0'b0 == 0 ? 1'b0 : 1'b0, 12'h000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h2, 12'h233},
        {1'b0, 12'h000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 12'h000}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Entered at a falling edge; drives one cycle, returns read data seen before the edge.
    task automatic tick(input logic pv, input logic [11:0] pd, input logic pp,
                        input logic lw, input logic le, input logic sc,
                        output logic [11:0] seen);
        push_valid = pv; push_entry = pd; rd_pop = pp;
        lcr_wr = lw; lcr_fifo_en = le; stat_clr = sc;
        #1 seen = rd_entry;
        @(negedge clk);
        push_valid = 1'b0; rd_pop = 1'b0; lcr_wr = 1'b0; stat_clr = 1'b0;
    endtask

    function automatic logic [11:0] ent(input int i);
        return {4'(i), 8'(8'h30 + i)};
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [11:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 empty", rx_empty, 1);
        check("R1 full", rx_full, 0);
        check("R1 irq", rx_irq, 0);
        check("R1 stat", rx_stat, 0);
        check("R1 ready", push_ready, 1);

        // Single-entry mode: R4, R3, R8
        tick(1, 12'h055, 0, 0, 0, 0, s);
        check("R4 full single", rx_full, 1);
        check("R3 ready low single", push_ready, 0);
        check("R8 irq set", rx_irq, 1);
        tick(1, 12'h066, 0, 0, 0, 0, s);    // dropped
        tick(0, 12'h000, 1, 0, 0, 0, s);
        check("R2 single read", s, 12'h055);
        check("R4 full cleared", rx_full, 0);
        check("R5 empty set", rx_empty, 1);
        check("R8 irq cleared", rx_irq, 0);
        tick(0, 12'h000, 1, 0, 0, 0, s);
        check("R3 dropped push not stored", s, 12'h000);

        // Enable buffering (flush), then table
        tick(0, 12'h000, 0, 1, 1, 0, s);
        check("R9 enable flush empty", rx_empty, 1);
        for (int i = 0; i < 8; i++) begin
            logic [33:0] v;
            v = VECS[i];
            tick(v[33], v[32:21], v[20], 0, 1, 0, s);
            if (v[20]) check("R2 R10 table read", s, v[11:0]);
            check("R3 table ready", push_ready, v[19]);
            check("R5 table empty", rx_empty, v[18]);
            check("R4 table full", rx_full, v[17]);
            check("R8 table irq", rx_irq, v[16]);
            check("R7 table stat", rx_stat, v[15:12]);
        end

        // Status capture and clear: R7
        tick(1, 12'h8FF, 0, 0, 1, 0, s);
        tick(0, 12'h000, 1, 0, 1, 0, s);
        check("R7 stat capture", rx_stat, 8);
        tick(0, 12'h000, 0, 0, 1, 1, s);
        check("R7 stat clear", rx_stat, 0);

        // Fill to 16 starting at slot 5: R4, R3, R11
        for (int i = 0; i < 16; i++) begin
            tick(1, ent(i), 0, 0, 1, 0, s);
            if (i == 14) begin
                check("R4 not full at 15", rx_full, 0);
                check("R3 ready at 15", push_ready, 1);
            end
        end
        check("R4 full at 16", rx_full, 1);
        check("R3 ready low at 16", push_ready, 0);
        tick(1, 12'hFFF, 0, 0, 1, 0, s);    // dropped
        for (int i = 0; i < 16; i++) begin
            tick(0, 12'h000, 1, 0, 1, 0, s);
            check("R2 R11 drain order", s, ent(i));
            if (i == 0) check("R4 full cleared by read", rx_full, 0);
        end
        check("R5 empty after drain", rx_empty, 1);
        check("R8 irq after drain", rx_irq, 0);
        tick(0, 12'h000, 1, 0, 1, 0, s);
        check("R6 R11 stale after wrap", s, ent(0));
        check("R6 still empty", rx_empty, 1);

        // Flush behaviour: R9
        tick(1, 12'h0AA, 0, 0, 1, 0, s);
        tick(1, 12'h0BB, 0, 0, 1, 0, s);
        tick(0, 12'h000, 0, 1, 1, 0, s);    // same value
        check("R9 same write keeps", rx_empty, 0);
        tick(0, 12'h000, 0, 1, 0, 0, s);    // toggle off
        check("R9 flush empty", rx_empty, 1);
        check("R9 flush irq", rx_irq, 0);
        check("R9 flush full", rx_full, 0);
        check("R9 flush ready", push_ready, 1);
        tick(0, 12'h000, 1, 0, 0, 0, s);
        check("R9 pointer at slot 0", s, ent(11));
        tick(1, 12'h400, 0, 0, 0, 0, s);
        check("R4 single after flush", rx_full, 1);
        tick(0, 12'h000, 1, 0, 0, 0, s);
        check("R2 break entry", s, 12'h400);
        check("R7 break flag", rx_stat, 4);

        finish_run();
    end
endmodule